// File: doc/BRIEF.md
# Dual-Tone Period Classifier

This block recognises a keypad tone pair by timing squared versions of the two tone components. One input carries the squared low-band component and the other carries the squared high-band component. Each input has its own meter, which counts system clock cycles between rising edges. A matcher then compares each measured period with four acceptance windows. The window bounds are worked out at elaboration from the clock rate and a tolerance given in tenths of a percent. With the defaults, the windows are ±2.5% around each nominal period, which sits between the ±1.5% that must be accepted and the ±3.5% that must be refused.

A band counts as locked only after several consecutive periods land in the same window. A period outside every window drops the lock. When both bands are locked at once, the block raises a pair flag and presents a row index and a column index. Those indices hold their values after the flag falls. An inhibit input removes the highest column from reporting. A power-down input stops all measurement and silences the flag.

Top module: `dual_tone_classifier`

## Requirements
- R1: The low band maps 697, 770, 852 and 941 Hz to row indices 0, 1, 2 and 3 on `row_o`.
- R2: The high band maps 1209, 1336, 1477 and 1633 Hz to column indices 0, 1, 2 and 3 on `col_o`.
- R3: A tone whose frequency is off nominal by up to ±1.5% is still classified to its nominal index.
- R4: A tone whose frequency is off nominal by 3.5% or more is not classified, and `pair_o` stays low.
- R5: A band locks only after four consecutive measured periods fall in the same window. The first rising edge after start or silence only opens the measurement. A period outside every window clears the lock.
- R6: `pair_o` is high only while both bands are locked. `row_o` and `col_o` update only when a pair is reported, and they keep their last values while `pair_o` is low.
- R7: While `inhibit_i` is high, a column-3 (1633 Hz) tone never raises `pair_o`. Columns 0 to 2 are unaffected.
- R8: While `pdn_i` is high, the meters and matchers are held cleared and `pair_o` is low from the first clock edge on which `pdn_i` is sampled high.
- R9: Each cycle counter saturates at its all-ones value and does not wrap. When it reaches saturation after a valid edge, the band's lock is cleared, so a silent input removes the pair.
- R10: After a synchronous reset, `pair_o`, `row_o` and `col_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; the period-counting timebase |
| rst_i | input | 1 | Synchronous active-high reset |
| low_sq_i | input | 1 | Squared low-band tone component |
| high_sq_i | input | 1 | Squared high-band tone component |
| inhibit_i | input | 1 | High: suppress column 3 |
| pdn_i | input | 1 | High: power-down, measurement stopped |
| pair_o | output | 1 | Both bands locked, indices valid |
| row_o | output | 2 | Low-band index of the last reported pair |
| col_o | output | 2 | High-band index of the last reported pair |

## Verification
Three register stages separate an input edge from the outputs. The edge sampled high at clock edge N loads the period register at N. The lock counter updates at N+1, and `pair_o`, `row_o` and `col_o` update at N+2. The bench therefore judges a tone pair only after at least half a period beyond the fifth rising edge of the slower band, and it samples on the falling clock edge. The lock-timing check samples half a period after the fourth and after the sixth edge, so the confirmation count is observed with margins far wider than the three-cycle latency. The power-down check samples at the falling edge right after the first rising edge that sees `pdn_i` high. The silence check samples once well inside the saturation interval and once past it.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int NTONES = 4;
  localparam int IDX_W  = $clog2(NTONES);

  // Nominal tone frequency in Hz; high selects the upper band.
  function automatic int tone_hz(input bit high, input int idx);
    int f;
    if (!high) begin
      case (idx)
        0: f = 697;
        1: f = 770;
        2: f = 852;
        default: f = 941;
      endcase
    end else begin
      case (idx)
        0: f = 1209;
        1: f = 1336;
        2: f = 1477;
        default: f = 1633;
      endcase
    end
    return f;
  endfunction

  // Period in clock cycles scaled by (1000 + permil) / 1000, rounded down.
  function automatic int period_bound(input longint clk_hz, input int hz, input int permil);
    longint num;
    num = clk_hz * longint'(1000 + permil);
    return int'(num / (longint'(hz) * 1000));
  endfunction
endpackage

// File: rtl/period_meter.sv
module period_meter #(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             clr_i,
  input  logic             sq_i,
  output logic             strobe_o,
  output logic [CNT_W-1:0] period_o
);
  localparam logic [CNT_W-1:0] CNT_TOP  = '1;
  localparam logic [CNT_W-1:0] CNT_NEAR = CNT_TOP - {{(CNT_W-1){1'b0}}, 1'b1};

  logic             sq_d;
  logic             primed;
  logic [CNT_W-1:0] cnt;
  logic             rise;

  assign rise = sq_i & ~sq_d;

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) begin
      sq_d     <= 1'b0;
      primed   <= 1'b0;
      cnt      <= '0;
      strobe_o <= 1'b0;
      period_o <= '0;
    end else begin
      sq_d     <= sq_i;
      strobe_o <= 1'b0;
      if (rise) begin
        cnt    <= {{(CNT_W-1){1'b0}}, 1'b1};
        primed <= 1'b1;
        if (primed) begin
          strobe_o <= 1'b1;
          period_o <= cnt;
        end
      end else if (cnt != CNT_TOP) begin
        cnt <= cnt + 1'b1;
        if (cnt == CNT_NEAR && primed) begin
          // silence: report an out-of-range period once
          strobe_o <= 1'b1;
          period_o <= CNT_TOP;
          primed   <= 1'b0;
        end
      end
    end
  end

  assert_cnt_saturates_R9: assert property (@(posedge clk_i) disable iff (rst_i || clr_i)
    (cnt == CNT_TOP && !rise) |=> (cnt == CNT_TOP));

  assert_no_wrap_R9: assert property (@(posedge clk_i) disable iff (rst_i || clr_i)
    (cnt == CNT_TOP) |=> (cnt != '0));
endmodule

// File: rtl/band_matcher.sv
module band_matcher
  import dtc_pkg::*;
#(
  parameter int     CNT_W      = 14,
  parameter longint CLK_HZ     = 3579545,
  parameter int     TOL_PERMIL = 25,
  parameter int     CONFIRM    = 4,
  parameter bit     HIGH_BAND  = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             clr_i,
  input  logic             strobe_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             matched_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int RUN_W = $clog2(CONFIRM + 1);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(CONFIRM);

  logic [NTONES-1:0] in_win;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [RUN_W-1:0]  run;
  logic [IDX_W-1:0]  cur_idx;

  for (genvar g = 0; g < NTONES; g++) begin : g_win
    localparam int LO = period_bound(CLK_HZ, tone_hz(HIGH_BAND, g), -TOL_PERMIL);
    localparam int HI = period_bound(CLK_HZ, tone_hz(HIGH_BAND, g),  TOL_PERMIL);
    assign in_win[g] = (int'(period_i) >= LO) && (int'(period_i) <= HI);
  end

  assign hit = |in_win;

  always_comb begin
    hit_idx = '0;
    for (int i = NTONES - 1; i >= 0; i--) begin
      if (in_win[i]) hit_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) begin
      run     <= '0;
      cur_idx <= '0;
    end else if (strobe_i) begin
      if (!hit) begin
        run <= '0;
      end else if (run != '0 && hit_idx == cur_idx) begin
        if (run != RUN_FULL) run <= run + 1'b1;
      end else begin
        run     <= {{(RUN_W-1){1'b0}}, 1'b1};
        cur_idx <= hit_idx;
      end
    end
  end

  assign matched_o = (run == RUN_FULL);
  assign idx_o     = cur_idx;

  assert_miss_clears_R5: assert property (@(posedge clk_i) disable iff (rst_i || clr_i)
    (strobe_i && !hit) |=> !matched_o);

  assert_lock_on_period_R5: assert property (@(posedge clk_i) disable iff (rst_i || clr_i)
    $rose(matched_o) |-> $past(strobe_i));
endmodule

// File: rtl/dual_tone_classifier.sv
module dual_tone_classifier
  import dtc_pkg::*;
#(
  parameter longint CLK_HZ     = 3579545,
  parameter int     CNT_W      = 14,
  parameter int     TOL_PERMIL = 25,
  parameter int     CONFIRM    = 4
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       low_sq_i,
  input  logic       high_sq_i,
  input  logic       inhibit_i,
  input  logic       pdn_i,
  output logic       pair_o,
  output logic [1:0] row_o,
  output logic [1:0] col_o
);
  localparam logic [IDX_W-1:0] TOP_COL = IDX_W'(NTONES - 1);

  logic [1:0]             strobe;
  logic [1:0][CNT_W-1:0]  period;
  logic [1:0]             matched;
  logic [1:0][IDX_W-1:0]  idx;
  logic [1:0]             sq;
  logic                   report;

  assign sq = {high_sq_i, low_sq_i};

  for (genvar b = 0; b < 2; b++) begin : g_band
    period_meter #(.CNT_W(CNT_W)) u_meter (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .clr_i    (pdn_i),
      .sq_i     (sq[b]),
      .strobe_o (strobe[b]),
      .period_o (period[b])
    );
    band_matcher #(
      .CNT_W      (CNT_W),
      .CLK_HZ     (CLK_HZ),
      .TOL_PERMIL (TOL_PERMIL),
      .CONFIRM    (CONFIRM),
      .HIGH_BAND  (b == 1)
    ) u_match (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .clr_i     (pdn_i),
      .strobe_i  (strobe[b]),
      .period_i  (period[b]),
      .matched_o (matched[b]),
      .idx_o     (idx[b])
    );
  end

  assign report = matched[0] && matched[1] && !(inhibit_i && idx[1] == TOP_COL);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pair_o <= 1'b0;
      row_o  <= '0;
      col_o  <= '0;
    end else if (pdn_i) begin
      pair_o <= 1'b0;
    end else begin
      pair_o <= report;
      if (report) begin
        row_o <= idx[0];
        col_o <= idx[1];
      end
    end
  end

  assert_pair_needs_both_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    pair_o |-> $past(matched[0] && matched[1]));

  assert_inhibit_top_col_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (pair_o && $past(inhibit_i)) |-> (col_o != TOP_COL));

  assert_pdn_silences_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    pdn_i |=> !pair_o);

  assert_indices_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !pair_o |-> ($stable(row_o) && $stable(col_o)));
endmodule

// File: tb/dual_tone_classifier_test.sv
module dual_tone_classifier_test;
  localparam int  CLK_PERIOD = 10;
  localparam real TB_CLK_HZ  = 357954.0;
  localparam int  TB_CNT_W   = 12;
  localparam int  CNT_TOP    = (1 << TB_CNT_W) - 1;
  localparam int  NV         = 10;

  // row, col, low deviation (permil), high deviation (permil), inhibit, expected pair
  localparam int VEC [NV][6] = '{
    '{0, 0,   0,   0, 0, 1},
    '{1, 2,   0,   0, 0, 1},
    '{3, 1,   0,   0, 0, 1},
    '{2, 3,   0,   0, 0, 1},
    '{2, 3,   0,   0, 1, 0},
    '{0, 1,  15, -15, 0, 1},
    '{3, 2, -15,  15, 0, 1},
    '{1, 0,  35,   0, 0, 0},
    '{2, 1,   0, -35, 0, 0},
    '{3, 0,   0,   0, 1, 1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inhibit = 1'b0;
  logic pdn = 1'b0;
  logic lo_sq = 1'b0;
  logic hi_sq = 1'b0;
  logic pair;
  logic [1:0] row;
  logic [1:0] col;
  int lo_per = 0;
  int hi_per = 0;
  int lo_ph = 0;
  int hi_ph = 0;
  int checks = 0;
  int fails = 0;
  int exp_row = 0;
  int exp_col = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_tone_classifier #(
    .CLK_HZ (357954),
    .CNT_W  (TB_CNT_W)
  ) uut (
    .clk_i     (clk),
    .rst_i     (rst),
    .low_sq_i  (lo_sq),
    .high_sq_i (hi_sq),
    .inhibit_i (inhibit),
    .pdn_i     (pdn),
    .pair_o    (pair),
    .row_o     (row),
    .col_o     (col)
  );

  initial forever begin
    @(negedge clk);
    if (lo_per <= 0) begin
      lo_ph = 0; lo_sq = 1'b0;
    end else begin
      lo_ph = (lo_ph >= lo_per) ? 1 : lo_ph + 1;
      lo_sq = (lo_ph <= lo_per / 2);
    end
  end

  initial forever begin
    @(negedge clk);
    if (hi_per <= 0) begin
      hi_ph = 0; hi_sq = 1'b0;
    end else begin
      hi_ph = (hi_ph >= hi_per) ? 1 : hi_ph + 1;
      hi_sq = (hi_ph <= hi_per / 2);
    end
  end

  function automatic int row_hz(input int i);
    case (i) 0: return 697; 1: return 770; 2: return 852; default: return 941; endcase
  endfunction

  function automatic int col_hz(input int i);
    case (i) 0: return 1209; 1: return 1336; 2: return 1477; default: return 1633; endcase
  endfunction

  function automatic int cycles_for(input int hz, input int dev_permil);
    real f;
    f = real'(hz) * (1.0 + real'(dev_permil) / 1000.0);
    return $rtoi(TB_CLK_HZ / f + 0.5);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    wait_cycles(4);
    // R10: reset state
    check(pair == 1'b0, "R10 pair", pair, 0);
    check(row == 2'd0 && col == 2'd0, "R10 indices", {row, col}, 0);
    rst = 1'b0;
    wait_cycles(2);

    // Table: R1, R2 classification, R3 accept, R4 reject, R7 inhibit, R6 hold
    for (int v = 0; v < NV; v++) begin
      int p_lo;
      int p_hi;
      int longest;
      p_lo = cycles_for(row_hz(VEC[v][0]), VEC[v][2]);
      p_hi = cycles_for(col_hz(VEC[v][1]), VEC[v][3]);
      lo_per  = p_lo;
      hi_per  = p_hi;
      inhibit = VEC[v][4][0];
      longest = (p_lo > p_hi) ? p_lo : p_hi;
      wait_cycles(10 * longest);
      check(pair == VEC[v][5][0], "R3/R4/R7 pair flag", pair, VEC[v][5]);
      if (VEC[v][5] != 0) begin
        exp_row = VEC[v][0];
        exp_col = VEC[v][1];
      end
      check(int'(row) == exp_row, "R1 row index", row, exp_row);
      check(int'(col) == exp_col, "R2 col index", col, exp_col);
    end
    inhibit = 1'b0;

    // R8: power-down drops the flag at the next edge and holds it low
    lo_per = cycles_for(770, 0);
    hi_per = cycles_for(1336, 0);
    wait_cycles(10 * lo_per);
    check(pair == 1'b1, "R8 pre-condition pair", pair, 1);
    pdn = 1'b1;
    wait_cycles(1);
    check(pair == 1'b0, "R8 pair after one edge", pair, 0);
    wait_cycles(3000);
    check(pair == 1'b0, "R8 pair held low", pair, 0);

    // R5: lock after four periods; restart both tones from a clean phase
    lo_per = 0;
    hi_per = 0;
    wait_cycles(4);
    pdn = 1'b0;
    wait_cycles(2);
    lo_per = cycles_for(770, 0);
    hi_per = cycles_for(1336, 0);
    wait_cycles(3 * lo_per + lo_per / 2);
    check(pair == 1'b0, "R5 three periods not enough", pair, 0);
    wait_cycles(2 * lo_per);
    check(pair == 1'b1, "R5 locked after four periods", pair, 1);
    check(row == 2'd1 && col == 2'd1, "R5 indices", {row, col}, 5);

    // R9: silent low band keeps lock until saturation, then clears
    lo_per = 0;
    wait_cycles(2000);
    check(pair == 1'b1, "R9 lock kept before saturation", pair, 1);
    wait_cycles(CNT_TOP + 400 - 2000);
    check(pair == 1'b0, "R9 silence clears pair", pair, 0);
    check(row == 2'd1 && col == 2'd1, "R6 indices held after drop", {row, col}, 5);

    finish_run();
  end
endmodule